// File: doc/BRIEF.md
# DMA Global Gate and Error-Flag Controller

This block holds the global run state for a multi-channel DMA engine whose channels are split into equal groups. Each group owns one control/status word with a master enable, a sticky address-error flag and a sticky NMI flag. The block screens every transfer request for a misaligned source or destination and for targets that are undefined or stopped, and it drives one registered "transfer permitted" line per channel. The data movers and address counters sample these permit lines. When a permit line falls, a transfer that is already running stops.

Software reaches the status words through a plain register port: a read strobe, a write strobe, a group select and a three-bit data field. The read data follows the selected group combinationally. A flag can only be cleared in two steps: a read that returns the flag as 1 arms it, and a later write of 0 to that bit clears it. Transfer requests arrive as a valid-qualified word without a ready signal. The checker accepts one request on every cycle and never applies back-pressure, so a requester never waits.

Top module: `dma_gate_ctrl`

## Requirements
- R1: After reset every master enable, address-error flag, NMI flag and permit output is 0, and the read data of each group is 0.
- R2: The status word layout is: bit 0 is the master enable (read/write), bit 1 is the address-error flag and bit 2 is the NMI flag. The read data shows the word of the group on the select input in the same cycle.
- R3: A valid request whose source or destination address is misaligned sets the address-error flag of the channel's group on the next clock edge. The channel's group is the channel index divided by the group size. A 2-bit size code of 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes, and an address is misaligned when any of its low (size code) bits is nonzero.
- R4: A valid request whose undefined-region input or stopped-target input is high sets the address-error flag of the channel's group. Bit 0 of each input is the source and bit 1 is the destination.
- R5: An address-error flag in one group removes the permits of that group's channels only.
- R6: A high NMI input sets the NMI flag of every group on the next edge, whether or not any enable is set.
- R7: A set NMI flag removes the permits of its group's channels, including those that were permitted.
- R8: A flag is cleared only by a write of 0 to its bit that follows a read returning that bit as 1. A write of 0 without such a read leaves the flag at 1.
- R9: Writing 1 to a flag bit has no effect on the flag.
- R10: A new set event disarms a pending clear. A set event in the same cycle as an armed write of 0 leaves the flag at 1.
- R11: A channel is permitted when its channel enable and its group's master enable are high and neither of its group's flags is set. The permit output is registered, so it changes on the clock edge after the enable or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected group's status word |
| reg_rd | input | 1 | Read strobe; arms the clear of every flag it returns as 1 |
| reg_sel | input | GRP_W | Group select |
| reg_wdata | input | 3 | Write data (bit 0 enable, bit 1 address error, bit 2 NMI) |
| reg_rdata | output | 3 | Status word of the selected group |
| chk_valid | input | 1 | Transfer request valid, accepted every cycle |
| chk_ch | input | CH_W | Channel index of the request |
| chk_src | input | AW | Source address |
| chk_dst | input | AW | Destination address |
| chk_size | input | 2 | Transfer size code |
| chk_undef | input | 2 | Undefined region flags (bit 0 source, bit 1 destination) |
| chk_stopped | input | 2 | Target in stop mode flags (bit 0 source, bit 1 destination) |
| nmi | input | 1 | Non-maskable interrupt input |
| ch_en | input | NCH | Per-channel enables |
| permit | output | NCH | Registered per-channel transfer permits |

## Verification
The bench builds the block with its defaults: two groups of six channels and 32-bit addresses. This puts the group boundary between channels 5 and 6 within reach, so a single request on either side of it shows that errors stay inside their group. All four size codes are exercised, and misalignment is placed in the source in some vectors and in the destination in others. The permit register is sampled both one and two edges after a flag rises, which tests the stated latency. The arm, clear, disarm and same-cycle set-versus-clear orders are each driven on a group's flags.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;
  localparam int unsigned CSR_W   = 3;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_AE  = 1;
  localparam int unsigned BIT_NMI = 2;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/dma_sticky_flag.sv
// Sticky flag with a read-then-write-zero clear handshake.
module dma_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_zero_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      // a fresh event always wins and demands a new read
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_zero_i && armed_q) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_grp_csr.sv
// One group's status word: master enable plus two sticky flags.
module dma_grp_csr
  import dma_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic             ae_set_i,
  input  logic             nmi_set_i,
  output logic             en_o,
  output logic             ae_o,
  output logic             nmi_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= 1'b0;
    else if (wr_i) en_o <= wdata_i[BIT_EN];
  end

  dma_sticky_flag u_ae (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (ae_set_i),
    .rd_i      (rd_i),
    .wr_zero_i (wr_i && !wdata_i[BIT_AE]),
    .flag_o    (ae_o)
  );

  dma_sticky_flag u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (nmi_set_i),
    .rd_i      (rd_i),
    .wr_zero_i (wr_i && !wdata_i[BIT_NMI]),
    .flag_o    (nmi_o)
  );
endmodule

// File: rtl/dma_addr_check.sv
// Screens one request per cycle and raises the error set line of its group.
module dma_addr_check #(
  parameter int unsigned NUM_GRP    = 2,
  parameter int unsigned CH_PER_GRP = 6,
  parameter int unsigned AW         = 32,
  localparam int unsigned NCH       = NUM_GRP * CH_PER_GRP,
  localparam int unsigned CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               valid_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic [AW-1:0]      src_i,
  input  logic [AW-1:0]      dst_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         undef_i,
  input  logic [1:0]         stopped_i,
  output logic [NUM_GRP-1:0] err_set_o
);
  logic [AW-1:0] low_mask;
  logic          misaligned;
  logic          region_bad;
  logic          ch_ok;
  logic [CH_W:0] grp_of;

  always_comb begin
    low_mask   = (AW'(1) << size_i) - AW'(1);
    misaligned = |(src_i & low_mask) || |(dst_i & low_mask);
    region_bad = |undef_i || |stopped_i;
    ch_ok      = {1'b0, ch_i} < (CH_W+1)'(NCH);
    grp_of     = {1'b0, ch_i} / (CH_W+1)'(CH_PER_GRP);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign err_set_o[g] = valid_i && ch_ok && (misaligned || region_bad)
                          && (grp_of == (CH_W+1)'(g));
  end
endmodule

// File: rtl/dma_permit.sv
// Registered per-channel transfer permit.
module dma_permit #(
  parameter int unsigned NUM_GRP    = 2,
  parameter int unsigned CH_PER_GRP = 6,
  localparam int unsigned NCH       = NUM_GRP * CH_PER_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ch_en_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic [NUM_GRP-1:0] grp_ae_i,
  input  logic [NUM_GRP-1:0] grp_nmi_i,
  output logic [NCH-1:0]     permit_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned G = c / CH_PER_GRP;
    always_ff @(posedge clk) begin
      if (!rst_n) permit_o[c] <= 1'b0;
      else        permit_o[c] <= ch_en_i[c] && grp_en_i[G]
                                 && !grp_ae_i[G] && !grp_nmi_i[G];
    end
  end
endmodule

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
  import dma_gate_pkg::*;
#(
  parameter int unsigned NUM_GRP    = 2,
  parameter int unsigned CH_PER_GRP = 6,
  parameter int unsigned AW         = 32,
  localparam int unsigned NCH       = NUM_GRP * CH_PER_GRP,
  localparam int unsigned CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [GRP_W-1:0] reg_sel,
  input  logic [CSR_W-1:0] reg_wdata,
  output logic [CSR_W-1:0] reg_rdata,
  input  logic             chk_valid,
  input  logic [CH_W-1:0]  chk_ch,
  input  logic [AW-1:0]    chk_src,
  input  logic [AW-1:0]    chk_dst,
  input  logic [1:0]       chk_size,
  input  logic [1:0]       chk_undef,
  input  logic [1:0]       chk_stopped,
  input  logic             nmi,
  input  logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   permit
);
  logic [NUM_GRP-1:0] grp_en, grp_ae, grp_nmi, ae_set, sel_hit;

  dma_addr_check #(
    .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP), .AW(AW)
  ) u_check (
    .valid_i   (chk_valid),
    .ch_i      (chk_ch),
    .src_i     (chk_src),
    .dst_i     (chk_dst),
    .size_i    (chk_size),
    .undef_i   (chk_undef),
    .stopped_i (chk_stopped),
    .err_set_o (ae_set)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_csr
    assign sel_hit[g] = (reg_sel == GRP_W'(g));
    dma_grp_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr && sel_hit[g]),
      .rd_i      (reg_rd && sel_hit[g]),
      .wdata_i   (reg_wdata),
      .ae_set_i  (ae_set[g]),
      .nmi_set_i (nmi),
      .en_o      (grp_en[g]),
      .ae_o      (grp_ae[g]),
      .nmi_o     (grp_nmi[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (sel_hit[g]) begin
        reg_rdata[BIT_EN]  = grp_en[g];
        reg_rdata[BIT_AE]  = grp_ae[g];
        reg_rdata[BIT_NMI] = grp_nmi[g];
      end
    end
  end

  dma_permit #(
    .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP)
  ) u_permit (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en_i   (ch_en),
    .grp_en_i  (grp_en),
    .grp_ae_i  (grp_ae),
    .grp_nmi_i (grp_nmi),
    .permit_o  (permit)
  );
endmodule

// File: rtl/dma_gate_ctrl_sva.sv
module dma_gate_ctrl_sva
  import dma_gate_pkg::*;
#(
  parameter int unsigned NUM_GRP    = 2,
  parameter int unsigned CH_PER_GRP = 6,
  localparam int unsigned NCH       = NUM_GRP * CH_PER_GRP,
  localparam int unsigned GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nmi,
  input logic               reg_wr,
  input logic [GRP_W-1:0]   reg_sel,
  input logic [CSR_W-1:0]   reg_wdata,
  input logic               chk_valid,
  input logic [NCH-1:0]     ch_en,
  input logic [NCH-1:0]     permit,
  input logic [NUM_GRP-1:0] grp_en,
  input logic [NUM_GRP-1:0] grp_ae,
  input logic [NUM_GRP-1:0] grp_nmi
);
  // R6: NMI sets every group's flag on the next edge
  a_r6_nmi_latch: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> &grp_nmi);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // R3 R4: an address error only appears after a request
    a_r3_ae_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_ae[g]) |-> $past(chk_valid));
    // R8: a flag falls only after a write of 0 to its group
    a_r8_ae_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grp_ae[g]) |-> $past(reg_wr && reg_sel == GRP_W'(g) && !reg_wdata[BIT_AE]));
    a_r8_nmi_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grp_nmi[g]) |-> $past(reg_wr && reg_sel == GRP_W'(g) && !reg_wdata[BIT_NMI]));
    // R10: a set NMI input never lets the flag drop
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !$fell(grp_nmi[g]));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned G = c / CH_PER_GRP;
    // R5 R7: a set flag removes the permit one edge later
    a_r7_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ae[G] || grp_nmi[G]) |=> !permit[c]);
    // R11: a permit rises only when its conditions held a cycle earlier
    a_r11_permit_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(permit[c]) |-> $past(ch_en[c] && grp_en[G]));
  end
endmodule

bind dma_gate_ctrl dma_gate_ctrl_sva #(
  .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .nmi       (nmi),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .chk_valid (chk_valid),
  .ch_en     (ch_en),
  .permit    (permit),
  .grp_en    (grp_en),
  .grp_ae    (grp_ae),
  .grp_nmi   (grp_nmi)
);

// File: tb/tb_dma_gate_ctrl.sv
module tb_dma_gate_ctrl;
  localparam int NCH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [0:0]  reg_sel = '0;
  logic [2:0]  reg_wdata = '0;
  logic [2:0]  reg_rdata;
  logic        chk_valid = 1'b0;
  logic [3:0]  chk_ch = '0;
  logic [31:0] chk_src = '0, chk_dst = '0;
  logic [1:0]  chk_size = '0, chk_undef = '0, chk_stopped = '0;
  logic        nmi = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH-1:0] permit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chk_valid(chk_valid), .chk_ch(chk_ch), .chk_src(chk_src),
    .chk_dst(chk_dst), .chk_size(chk_size), .chk_undef(chk_undef),
    .chk_stopped(chk_stopped), .nmi(nmi), .ch_en(ch_en), .permit(permit)
  );

  // {size, src_lo, dst_lo, undef, stopped, ch, expect_error}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'h03, 8'h07, 2'b00, 2'b00, 4'd2,  1'b0},
    {2'd1, 8'h02, 8'h11, 2'b00, 2'b00, 4'd2,  1'b1},
    {2'd1, 8'h04, 8'h06, 2'b00, 2'b00, 4'd8,  1'b0},
    {2'd2, 8'h08, 8'h0C, 2'b00, 2'b00, 4'd8,  1'b0},
    {2'd2, 8'h06, 8'h10, 2'b00, 2'b00, 4'd3,  1'b1},
    {2'd3, 8'h10, 8'h28, 2'b00, 2'b00, 4'd3,  1'b0},
    {2'd3, 8'h14, 8'h20, 2'b00, 2'b00, 4'd9,  1'b1},
    {2'd3, 8'h08, 8'h0C, 2'b00, 2'b00, 4'd11, 1'b1},
    {2'd0, 8'h00, 8'h00, 2'b01, 2'b00, 4'd0,  1'b1},
    {2'd0, 8'h00, 8'h00, 2'b10, 2'b00, 4'd6,  1'b1},
    {2'd2, 8'h00, 8'h04, 2'b00, 2'b01, 4'd5,  1'b1},
    {2'd2, 8'h00, 8'h04, 2'b00, 2'b10, 4'd7,  1'b1},
    {2'd3, 8'h40, 8'h80, 2'b00, 2'b00, 4'd10, 1'b0}
  };

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic peek(input logic g, output logic [2:0] d);
    reg_sel = g; #1 d = reg_rdata;
  endtask

  task automatic rd(input logic g, output logic [2:0] d);
    reg_rd = 1'b1; reg_sel = g; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic g, input logic [2:0] d);
    reg_wr = 1'b1; reg_sel = g; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic req(input logic [3:0] ch, input logic [1:0] sz, input logic [31:0] s,
                     input logic [31:0] t, input logic [1:0] un, input logic [1:0] st);
    chk_valid = 1'b1; chk_ch = ch; chk_size = sz; chk_src = s; chk_dst = t;
    chk_undef = un; chk_stopped = st;
    @(negedge clk);
    chk_valid = 1'b0; chk_undef = '0; chk_stopped = '0;
  endtask

  task automatic pulse_nmi();
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
  endtask

  task automatic clear_all(input logic g);
    logic [2:0] d;
    rd(g, d); wr(g, 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b0, d); check("R1 grp0 word", 12'(d), 12'h0);
    peek(1'b1, d); check("R1 grp1 word", 12'(d), 12'h0);
    check("R1 permit", permit, '0);

    // R2 layout, R9 flag bits written as 1 stay clear
    wr(1'b0, 3'b001);
    peek(1'b0, d); check("R2 enable readback", 12'(d), 12'h1);
    wr(1'b1, 3'b111);
    peek(1'b1, d); check("R9 write 1 to flags", 12'(d), 12'h1);

    // R11 permit follows enables
    ch_en = '1;
    @(negedge clk);
    check("R11 all permitted", permit, 12'hFFF);

    // R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] ch;
      logic       g;
      ch = VEC[i][4:1];
      g  = (ch >= 4'd6);
      req(ch, VEC[i][26:25], {24'h5A5A00, VEC[i][24:17]}, {24'h3C3C00, VEC[i][16:9]},
          VEC[i][8:7], VEC[i][6:5]);
      peek(g, d);
      check($sformatf("R3 R4 vector %0d own group", i), 12'(d[1]), 12'(VEC[i][0]));
      peek(!g, d);
      check($sformatf("R3 R4 vector %0d other group", i), 12'(d[1]), 12'h0);
      if (VEC[i][0]) clear_all(g);
      @(negedge clk);
    end

    // R5 group isolation and R11 latency
    req(4'd7, 2'd1, 32'h1001, 32'h2000, 2'b00, 2'b00);
    check("R11 permit one edge later", permit, 12'hFFF);
    @(negedge clk);
    check("R5 only group 1 blocked", permit, 12'h03F);

    // R8 clear handshake
    wr(1'b1, 3'b001);
    peek(1'b1, d); check("R8 write 0 without read", 12'(d), 12'h3);
    rd(1'b1, d); check("R8 read returns flag", 12'(d), 12'h3);
    wr(1'b1, 3'b001);
    peek(1'b1, d); check("R8 cleared after read", 12'(d), 12'h1);
    @(negedge clk);
    check("R8 permits restored", permit, 12'hFFF);

    // R6 NMI while idle
    wr(1'b0, 3'b000); wr(1'b1, 3'b000);
    pulse_nmi();
    peek(1'b0, d); check("R6 grp0 NMI idle", 12'(d), 12'h4);
    peek(1'b1, d); check("R6 grp1 NMI idle", 12'(d), 12'h4);

    // R10 set wins over armed clear
    rd(1'b0, d);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 3'b000; nmi = 1'b1;
    @(negedge clk); reg_wr = 1'b0; nmi = 1'b0;
    peek(1'b0, d); check("R10 set wins", 12'(d), 12'h4);
    // R10 new set disarms
    rd(1'b0, d);
    pulse_nmi();
    wr(1'b0, 3'b000);
    peek(1'b0, d); check("R10 disarmed by set", 12'(d), 12'h4);
    clear_all(1'b0); clear_all(1'b1);
    peek(1'b0, d); check("R8 grp0 NMI cleared", 12'(d), 12'h1);
    @(negedge clk);
    check("R11 permits back", permit, 12'hFFF);

    // R7 NMI stops running transfers
    pulse_nmi();
    check("R7 permit still registered", permit, 12'hFFF);
    @(negedge clk);
    check("R7 NMI blocks all", permit, 12'h000);
    clear_all(1'b0); clear_all(1'b1);
    @(negedge clk);

    // R11 master and channel enables
    wr(1'b0, 3'b000);
    @(negedge clk);
    check("R11 grp0 master off", permit, 12'hFC0);
    ch_en = 12'h0F0;
    @(negedge clk);
    check("R11 channel mask", permit, 12'h0C0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule